// File: doc/BRIEF.md
# External Code and Data Bus Controller

This block sits between the core of an 8-bit microcontroller and its memories. It steers every code fetch either to the on-chip ROM port or to a multiplexed external bus. It also runs the external data reads and writes. A strap input and the on-chip ROM size parameter decide where a fetch goes. With the strap high, fetches below the ROM size stay on chip. With the strap low, every fetch leaves the chip. Code addresses are always 16 bits wide.

The external bus uses two 8-bit ports. The shared port first carries the low address byte, which is qualified by an address strobe so that an outside latch can capture it. In the same port the byte then travels: code or read data in, or write data out. The upper port carries the high address byte for code fetches and for data accesses with a 16-bit address. For 8-bit data addresses the upper port is released to general I/O. Code fetches and data reads and writes each have their own active-low strobe.

Requests are levels. The requester holds a request until the matching done pulse and drops it in that cycle. The controller samples requests only while idle. A pending fetch wins over a pending data access.

Top module: `mcu_xbus`

## Requirements
- R1: After synchronous reset the address strobe is low, all three active-low strobes are high, neither port is driven, the ROM read enable is low and both done outputs are low.
- R2: With the strap high, a fetch whose address is below ROM_BYTES reads the ROM port and causes no external bus activity. fetch_done rises in the third cycle after the request is sampled, carrying the ROM byte.
- R3: A fetch at or above ROM_BYTES with the strap high, and every fetch with the strap low, goes to the external bus and never to the ROM port.
- R4: The code strobe goes low only in the data phase of an external fetch, for exactly STROBE_CYC cycles, and never during internal fetches or data accesses.
- R5: Each external access first drives the low address byte on the shared port with the address strobe high for one cycle. It then holds that byte for one cycle with the strobe low, and only after that lowers an access strobe. During a read or fetch data phase the shared port is tri-stated, and the byte on ad_in in the last strobe cycle is returned.
- R6: The upper port drives the high address byte for all STROBE_CYC+3 cycles of an external fetch or a 16-bit-address data access. For an 8-bit-address data access it is not driven at all.
- R7: A data read lowers only the read strobe. A data write lowers only the write strobe for STROBE_CYC cycles while the shared port drives the write byte.
- R8: Each access ends with exactly one one-cycle done pulse on the matching output. For an external access this comes STROBE_CYC+3 cycles after the request is sampled.
- R9: When a fetch and a data request are both pending in idle, the fetch completes first. The held data request starts in the cycle after the controller returns to idle.
- R10: Code addresses use all 16 bits, so a fetch at FFFFh puts FFh on the upper port and FFh on the shared port in the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_int_rom | input | 1 | High: on-chip ROM serves low addresses |
| fetch_req | input | 1 | Code fetch request, held until fetch_done |
| fetch_addr | input | 16 | Code address |
| fetch_done | output | 1 | One-cycle fetch completion pulse |
| fetch_data | output | 8 | Fetched code byte |
| data_req | input | 1 | External data request, held until data_done |
| data_we | input | 1 | 1 = write, 0 = read |
| data_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| data_addr | input | 16 | Data address (upper byte unused when narrow) |
| data_wdata | input | 8 | Write byte |
| data_done | output | 1 | One-cycle data completion pulse |
| data_rdata | output | 8 | Read byte |
| irom_rd | output | 1 | ROM read enable |
| irom_addr | output | 16 | ROM address |
| irom_data | input | 8 | ROM data, valid the cycle after irom_rd |
| ad_in | input | 8 | Shared port input |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ahi_out | output | 8 | Upper port output value |
| ahi_oe | output | 1 | Upper port owned by the bus |
| addr_strobe | output | 1 | High while the low address byte is on the shared port |
| code_rd_n | output | 1 | Active-low code fetch strobe |
| dmem_rd_n | output | 1 | Active-low data read strobe |
| dmem_wr_n | output | 1 | Active-low data write strobe |

## Verification
The hardest case to reach is a fetch and a data request that become pending in the same idle cycle. The data request must then survive the whole fetch and start at the right cycle. The bench raises both requests on one edge and records the cycle of each done pulse. It checks that the data access is served one idle cycle after the fetch ends. The routing boundary is covered by sweeping addresses on both sides of ROM_BYTES under both strap levels. A bench latch model rebuilds each address from the strobed low byte, so that every returned byte depends on a correct address phase.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef enum logic [2:0] {
    S_IDLE, S_IRD, S_IWAIT, S_IEND, S_ADDR, S_LATCH, S_DATA, S_END
  } xst_t;

  typedef enum logic [1:0] {K_CODE, K_DREAD, K_DWRITE} kind_t;

  typedef struct packed {
    kind_t              kind;
    logic               wide;
    logic               internal;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  wdata;
  } xreq_t;
endpackage

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int ROM_BYTES = 4096
) (
  input  logic              strap,
  input  logic [ADDR_W-1:0] addr,
  output logic              internal
);
  localparam int SPACE = 2 ** ADDR_W;

  generate
    if (ROM_BYTES <= 0) begin : g_none
      assign internal = 1'b0;
    end else if (ROM_BYTES >= SPACE) begin : g_full
      assign internal = strap;
    end else begin : g_part
      localparam logic [ADDR_W-1:0] ROM_TOP = ADDR_W'(ROM_BYTES);
      assign internal = strap && (addr < ROM_TOP);
    end
  endgenerate
endmodule

// File: rtl/xbus_arb.sv
module xbus_arb
  import xbus_pkg::*;
(
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_internal,
  input  logic              data_req,
  input  logic              data_we,
  input  logic              data_wide,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic              go,
  output xreq_t             req
);
  always_comb begin
    go = fetch_req || data_req;
    if (fetch_req) begin
      req.kind     = K_CODE;
      req.wide     = 1'b1;
      req.internal = fetch_internal;
      req.addr     = fetch_addr;
      req.wdata    = '0;
    end else begin
      req.kind     = data_we ? K_DWRITE : K_DREAD;
      req.wide     = data_wide;
      req.internal = 1'b0;
      req.addr     = data_addr;
      req.wdata    = data_wdata;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  xreq_t             req_in,
  input  logic [DATA_W-1:0] irom_data,
  input  logic [DATA_W-1:0] ad_in,
  output logic              fetch_done,
  output logic              data_done,
  output logic [DATA_W-1:0] fetch_data,
  output logic [DATA_W-1:0] data_rdata,
  output logic              irom_rd,
  output logic [ADDR_W-1:0] irom_addr,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   ahi_out,
  output logic              ahi_oe,
  output logic              addr_strobe,
  output logic              code_rd_n,
  output logic              dmem_rd_n,
  output logic              dmem_wr_n
);
  localparam int CW = $clog2(STROBE_CYC + 1);
  localparam logic [CW-1:0] CLAST = CW'(STROBE_CYC - 1);

  xst_t        st, nst;
  xreq_t       cur, ncur;
  logic [CW-1:0] cnt;
  logic        ext, aph, is_code, is_wr, is_rd, hi_own;

  always_comb begin
    nst  = st;
    ncur = cur;
    unique case (st)
      S_IDLE: if (go) begin
        ncur = req_in;
        nst  = (req_in.kind == K_CODE && req_in.internal) ? S_IRD : S_ADDR;
      end
      S_IRD:   nst = S_IWAIT;
      S_IWAIT: nst = S_IEND;
      S_IEND:  nst = S_IDLE;
      S_ADDR:  nst = S_LATCH;
      S_LATCH: nst = S_DATA;
      S_DATA:  if (cnt == CLAST) nst = S_END;
      S_END:   nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
    ext     = (nst == S_ADDR) || (nst == S_LATCH) || (nst == S_DATA) || (nst == S_END);
    aph     = (nst == S_ADDR) || (nst == S_LATCH);
    is_code = (ncur.kind == K_CODE);
    is_wr   = (ncur.kind == K_DWRITE);
    is_rd   = (ncur.kind == K_DREAD);
    hi_own  = ext && (is_code || ncur.wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cur         <= '0;
      cnt         <= '0;
      addr_strobe <= 1'b0;
      code_rd_n   <= 1'b1;
      dmem_rd_n   <= 1'b1;
      dmem_wr_n   <= 1'b1;
      ad_oe       <= 1'b0;
      ad_out      <= '0;
      ahi_oe      <= 1'b0;
      ahi_out     <= '0;
      irom_rd     <= 1'b0;
      irom_addr   <= '0;
      fetch_done  <= 1'b0;
      data_done   <= 1'b0;
      fetch_data  <= '0;
      data_rdata  <= '0;
    end else begin
      st          <= nst;
      cur         <= ncur;
      cnt         <= (st == S_DATA) ? cnt + 1'b1 : '0;
      addr_strobe <= (nst == S_ADDR);
      ad_oe       <= aph || (ext && is_wr);
      ad_out      <= aph ? ncur.addr[DATA_W-1:0] : ((ext && is_wr) ? ncur.wdata : '0);
      ahi_oe      <= hi_own;
      ahi_out     <= hi_own ? ncur.addr[ADDR_W-1:DATA_W] : '0;
      code_rd_n   <= !((nst == S_DATA) && is_code);
      dmem_rd_n   <= !((nst == S_DATA) && is_rd);
      dmem_wr_n   <= !((nst == S_DATA) && is_wr);
      irom_rd     <= (nst == S_IRD);
      if (nst == S_IRD) irom_addr <= ncur.addr;
      fetch_done  <= (nst == S_IEND) || ((nst == S_END) && is_code);
      data_done   <= (nst == S_END) && !is_code;
      if (st == S_IWAIT) fetch_data <= irom_data;
      if (st == S_DATA && nst == S_END) begin
        if (cur.kind == K_CODE)       fetch_data <= ad_in;
        else if (cur.kind == K_DREAD) data_rdata <= ad_in;
      end
    end
  end
endmodule

// File: rtl/mcu_xbus.sv
module mcu_xbus
  import xbus_pkg::*;
#(
  parameter int ROM_BYTES  = 4096,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_int_rom,
  input  logic              fetch_req,
  input  logic [15:0]       fetch_addr,
  output logic              fetch_done,
  output logic [7:0]        fetch_data,
  input  logic              data_req,
  input  logic              data_we,
  input  logic              data_wide,
  input  logic [15:0]       data_addr,
  input  logic [7:0]        data_wdata,
  output logic              data_done,
  output logic [7:0]        data_rdata,
  output logic              irom_rd,
  output logic [15:0]       irom_addr,
  input  logic [7:0]        irom_data,
  input  logic [7:0]        ad_in,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  output logic [7:0]        ahi_out,
  output logic              ahi_oe,
  output logic              addr_strobe,
  output logic              code_rd_n,
  output logic              dmem_rd_n,
  output logic              dmem_wr_n
);
  logic  fetch_internal;
  logic  go;
  xreq_t req;

  xbus_route #(.ROM_BYTES(ROM_BYTES)) u_route (
    .strap    (strap_int_rom),
    .addr     (fetch_addr),
    .internal (fetch_internal)
  );

  xbus_arb u_arb (
    .fetch_req      (fetch_req),
    .fetch_addr     (fetch_addr),
    .fetch_internal (fetch_internal),
    .data_req       (data_req),
    .data_we        (data_we),
    .data_wide      (data_wide),
    .data_addr      (data_addr),
    .data_wdata     (data_wdata),
    .go             (go),
    .req            (req)
  );

  xbus_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .req_in      (req),
    .irom_data   (irom_data),
    .ad_in       (ad_in),
    .fetch_done  (fetch_done),
    .data_done   (data_done),
    .fetch_data  (fetch_data),
    .data_rdata  (data_rdata),
    .irom_rd     (irom_rd),
    .irom_addr   (irom_addr),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .ahi_out     (ahi_out),
    .ahi_oe      (ahi_oe),
    .addr_strobe (addr_strobe),
    .code_rd_n   (code_rd_n),
    .dmem_rd_n   (dmem_rd_n),
    .dmem_wr_n   (dmem_wr_n)
  );
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
  input logic clk,
  input logic rst,
  input logic fetch_done,
  input logic data_done,
  input logic irom_rd,
  input logic ad_oe,
  input logic ahi_oe,
  input logic addr_strobe,
  input logic code_rd_n,
  input logic dmem_rd_n,
  input logic dmem_wr_n
);
  // R1
  idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!addr_strobe && code_rd_n && dmem_rd_n && dmem_wr_n && !ad_oe && !ahi_oe));

  // R4
  code_strobe_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
    !code_rd_n |-> !irom_rd);

  // R5
  strobe_after_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(code_rd_n) || $fell(dmem_rd_n) || $fell(dmem_wr_n)) |-> (!addr_strobe && !$past(addr_strobe)));

  // R5
  read_float_chk: assert property (@(posedge clk) disable iff (rst)
    (!code_rd_n || !dmem_rd_n) |-> !ad_oe);

  // R6
  code_hi_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !code_rd_n |-> ahi_oe);

  // R7
  write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !dmem_wr_n |-> ad_oe);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({!code_rd_n, !dmem_rd_n, !dmem_wr_n}) <= 1);

  // R8
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done);

  // R8
  data_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_done |=> !data_done);
endmodule

bind mcu_xbus xbus_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_done  (fetch_done),
  .data_done   (data_done),
  .irom_rd     (irom_rd),
  .ad_oe       (ad_oe),
  .ahi_oe      (ahi_oe),
  .addr_strobe (addr_strobe),
  .code_rd_n   (code_rd_n),
  .dmem_rd_n   (dmem_rd_n),
  .dmem_wr_n   (dmem_wr_n)
);

// File: tb/mcu_xbus_test.sv
`timescale 1ns/1ps
module mcu_xbus_test;
  localparam int ROMB = 4096;
  localparam int SC   = 2;
  localparam int EXT_LAT = SC + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_int_rom = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_done;
  logic [7:0]  fetch_data;
  logic        data_req = 1'b0;
  logic        data_we = 1'b0;
  logic        data_wide = 1'b0;
  logic [15:0] data_addr = '0;
  logic [7:0]  data_wdata = '0;
  logic        data_done;
  logic [7:0]  data_rdata;
  logic        irom_rd;
  logic [15:0] irom_addr;
  logic [7:0]  irom_q = '0;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ahi_out;
  logic        ahi_oe;
  logic        addr_strobe;
  logic        code_rd_n, dmem_rd_n, dmem_wr_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mcu_xbus #(.ROM_BYTES(ROMB), .STROBE_CYC(SC)) uut (
    .clk(clk), .rst(rst), .strap_int_rom(strap_int_rom),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done), .fetch_data(fetch_data),
    .data_req(data_req), .data_we(data_we), .data_wide(data_wide), .data_addr(data_addr),
    .data_wdata(data_wdata), .data_done(data_done), .data_rdata(data_rdata),
    .irom_rd(irom_rd), .irom_addr(irom_addr), .irom_data(irom_q),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ahi_out(ahi_out), .ahi_oe(ahi_oe),
    .addr_strobe(addr_strobe), .code_rd_n(code_rd_n), .dmem_rd_n(dmem_rd_n), .dmem_wr_n(dmem_wr_n)
  );

  function automatic logic [7:0] rom_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] code_f(input logic [15:0] a);
    return a[7:0] + 8'd3 * a[15:8] + 8'h11;
  endfunction
  function automatic logic [7:0] dat_f(input logic [15:0] a);
    return ~a[7:0] ^ {a[12:8], a[15:13]};
  endfunction

  // on-chip ROM model: one cycle read
  always @(posedge clk) if (irom_rd) irom_q <= rom_f(irom_addr);

  // external address latch and memory model
  logic [7:0] lat = '0;
  always @(negedge addr_strobe) lat <= ad_out;
  assign ad_in = !code_rd_n ? code_f({ahi_out, lat}) :
                 (!dmem_rd_n ? dat_f({(ahi_oe ? ahi_out : 8'h00), lat}) : 8'h00);

  // bus monitor
  int code_cnt, rd_cnt, wr_cnt, irom_cnt, stb_cnt, hi_cnt, done_cnt;
  logic bad_lo, bad_hi;
  logic [7:0]  stb_lo, wr_byte, cur_hi;
  logic [15:0] wr_a;

  task automatic clr_mon();
    code_cnt = 0; rd_cnt = 0; wr_cnt = 0; irom_cnt = 0; stb_cnt = 0; hi_cnt = 0; done_cnt = 0;
    bad_lo = 1'b0; bad_hi = 1'b0; stb_lo = '0; wr_byte = '0; wr_a = '0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!code_rd_n) begin
        code_cnt++;
        if (ad_oe) bad_lo = 1'b1;
      end
      if (!dmem_rd_n) begin
        rd_cnt++;
        if (ad_oe) bad_lo = 1'b1;
      end
      if (!dmem_wr_n) begin
        wr_cnt++;
        wr_byte = ad_out;
        wr_a = {(ahi_oe ? ahi_out : 8'h00), lat};
        if (!ad_oe) bad_lo = 1'b1;
      end
      if (irom_rd) irom_cnt++;
      if (addr_strobe) begin
        stb_cnt++;
        stb_lo = ad_out;
        if (!ad_oe) bad_lo = 1'b1;
      end
      if (ahi_oe) begin
        hi_cnt++;
        if (ahi_out != cur_hi) bad_hi = 1'b1;
      end
      if (fetch_done) done_cnt++;
      if (data_done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, input bit exp_int, input string rtag);
    int n;
    logic [7:0] got;
    @(negedge clk);
    clr_mon();
    cur_hi = a[15:8];
    fetch_addr = a;
    fetch_req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fetch_done && n < 40);
    fetch_req = 1'b0;
    got = fetch_data;
    @(negedge clk);
    @(negedge clk);
    if (exp_int) begin
      chk(irom_cnt == 1 && code_cnt == 0 && stb_cnt == 0 && hi_cnt == 0, "R2", "internal route", irom_cnt, 1);
      chk(got == rom_f(a), "R2", "rom byte", got, rom_f(a));
      chk(n == 3, "R2", "internal latency", n, 3);
    end else begin
      chk(irom_cnt == 0 && code_cnt > 0, rtag, "external route", irom_cnt, 0);
      chk(code_cnt == SC, "R4", "code strobe cycles", code_cnt, SC);
      chk(stb_cnt == 1 && stb_lo == a[7:0] && !bad_lo, "R5", "address phase low byte", stb_lo, a[7:0]);
      chk(got == code_f(a), "R5", "external code byte", got, code_f(a));
      chk(hi_cnt == EXT_LAT && !bad_hi, "R6", "upper port cycles", hi_cnt, EXT_LAT);
      chk(n == EXT_LAT, "R8", "external latency", n, EXT_LAT);
    end
    chk(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
  endtask

  task automatic do_data(input bit we, input bit wide, input logic [15:0] a, input logic [7:0] wd);
    int n;
    logic [7:0] got;
    logic [15:0] ea;
    ea = wide ? a : {8'h00, a[7:0]};
    @(negedge clk);
    clr_mon();
    cur_hi = a[15:8];
    data_addr = a; data_we = we; data_wide = wide; data_wdata = wd;
    data_req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!data_done && n < 40);
    data_req = 1'b0;
    got = data_rdata;
    @(negedge clk);
    @(negedge clk);
    chk(code_cnt == 0 && irom_cnt == 0, "R4", "no code strobe on data", code_cnt, 0);
    chk(stb_cnt == 1 && stb_lo == a[7:0] && !bad_lo, "R5", "data address phase", stb_lo, a[7:0]);
    chk(hi_cnt == (wide ? EXT_LAT : 0) && !bad_hi, "R6", "upper port use", hi_cnt, wide ? EXT_LAT : 0);
    if (we) begin
      chk(wr_cnt == SC && rd_cnt == 0, "R7", "write strobe", wr_cnt, SC);
      chk(wr_byte == wd && wr_a == ea, "R7", "write byte/addr", {wr_a, wr_byte}, {ea, wd});
    end else begin
      chk(rd_cnt == SC && wr_cnt == 0, "R7", "read strobe", rd_cnt, SC);
      chk(got == dat_f(ea), "R7", "read byte", got, dat_f(ea));
    end
    chk(n == EXT_LAT && done_cnt == 1, "R8", "data done timing", n, EXT_LAT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_mon();
    cur_hi = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!addr_strobe && code_rd_n && dmem_rd_n && dmem_wr_n, "R1", "strobes idle",
        {addr_strobe, code_rd_n, dmem_rd_n, dmem_wr_n}, 4'b0111);
    chk(!ad_oe && !ahi_oe && !irom_rd && !fetch_done && !data_done, "R1", "ports released",
        {ad_oe, ahi_oe, irom_rd, fetch_done, data_done}, 0);

    // R2/R3 strap high sweep across the ROM boundary
    strap_int_rom = 1'b1;
    do_fetch(16'h0000, 1'b1, "R3");
    do_fetch(16'h0FFF, 1'b1, "R3");
    do_fetch(16'h1000, 1'b0, "R3");
    for (int i = 0; i < 32; i++) begin
      logic [15:0] a;
      a = 16'(i * 2048 + i * 37);
      do_fetch(a, a < ROMB, "R3");
    end

    // R10 top of the code space
    do_fetch(16'hFFFF, 1'b0, "R10");
    chk(stb_lo == 8'hFF, "R10", "low byte of FFFF", stb_lo, 8'hFF);

    // R3 strap low: all fetches external
    strap_int_rom = 1'b0;
    do_fetch(16'h0000, 1'b0, "R3");
    do_fetch(16'h0FFF, 1'b0, "R3");
    for (int i = 0; i < 16; i++) do_fetch(16'(i * 4096 + i * 13), 1'b0, "R3");

    // R6/R7 data accesses
    for (int i = 0; i < 8; i++) begin
      do_data(1'b0, 1'b0, 16'(i * 8219 + 5), 8'h00);
      do_data(1'b0, 1'b1, 16'(i * 8219 + 5), 8'h00);
      do_data(1'b1, 1'b0, 16'(i * 7001 + 3), 8'(i * 29 + 1));
      do_data(1'b1, 1'b1, 16'(i * 7001 + 3), 8'(i * 53 + 7));
    end

    // R9 simultaneous requests: fetch first, held data request next
    begin
      int k, ft, dt;
      logic [7:0] fgot, dgot;
      ft = -1; dt = -1; k = 0;
      @(negedge clk);
      fetch_addr = 16'h2345; fetch_req = 1'b1;
      data_addr = 16'h1234; data_we = 1'b0; data_wide = 1'b1; data_req = 1'b1;
      while ((ft < 0 || dt < 0) && k < 60) begin
        @(negedge clk);
        k++;
        if (fetch_done && ft < 0) begin ft = k; fetch_req = 1'b0; fgot = fetch_data; end
        if (data_done && dt < 0) begin dt = k; data_req = 1'b0; dgot = data_rdata; end
      end
      chk(ft == EXT_LAT, "R9", "fetch served first", ft, EXT_LAT);
      chk(dt == ft + EXT_LAT + 1, "R9", "data served after idle", dt, ft + EXT_LAT + 1);
      chk(fgot == code_f(16'h2345), "R9", "fetch byte", fgot, code_f(16'h2345));
      chk(dgot == dat_f(16'h1234), "R9", "data byte", dgot, dat_f(16'h1234));
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule